// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Increment Pointer

This block is the serial host port of a battery charge monitor. It samples the two-wire bus lines (SCL, SDA) with the system clock and finds START, repeated START and STOP. It answers one fixed 7-bit address and keeps an eight-byte register map behind a register pointer. The first byte after an address-plus-write is a command byte, and that byte loads the pointer. Every later byte goes to the register the pointer selects, and the pointer then moves on by one. A read is normally an address-plus-write, a command byte, a repeated START and an address-plus-read. The slave then sends the selected register. Each byte the master acknowledges moves the pointer on and starts the next register.

The block also answers the shared alert-response address, but only while the device's alert input is high. Its reply is its own address. The rest of the device gets single-cycle write strobes (address and data) and read strobes (address), so that it can act on accesses such as clearing status on read. The charge counter loads the 16-bit accumulated charge through a parallel port. The charge LSB is captured when the MSB is read, so a two-byte read returns a consistent pair.

The SDA output is an open-drain enable: when it is high, the pad pulls the line low. There is no clock stretching and no data-stream handshake. All device-side pins are plain control and status signals.

Top module: `gauge_bus_slave`

## Requirements
- R1: After reset the map holds control = 3Ch, charge = 7FFFh, high threshold = FFFFh and low threshold = 0000h. Register offsets are: 00h status (read only, taken from `status_i`), 01h control, 02h/03h charge MSB/LSB, 04h/05h high threshold MSB/LSB, 06h/07h low threshold MSB/LSB.
- R2: The slave acknowledges only address 1100100 (the byte C8h for a write, C9h for a read). For any other address it leaves SDA released for the whole transaction and changes no register.
- R3: In a write, the slave acknowledges the address, the command byte and every data byte. The command byte's low three bits load the pointer. Each data byte is stored in the selected register with one single-cycle `wr_stb_o` pulse.
- R4: After each data byte written, the pointer advances by one and wraps from 07h to 00h, so one burst can fill consecutive registers.
- R5: A data byte written to 00h is acknowledged and advances the pointer. It raises no write strobe and changes no register.
- R6: After address-plus-read, the slave sends the register at the pointer, MSB first. It changes SDA only in the first low phase of each SCL period.
- R7: When the master acknowledges a read byte, the pointer advances (wrapping at 07h) and the next register is sent. After a not-acknowledge, the slave releases SDA and stays silent until the next START.
- R8: A read on address 0001100 (byte 19h) is acknowledged only while `alert_i` is high. The reply byte is C9h, and `ara_done_o` pulses once after that byte completes. While `alert_i` is low, the slave does not acknowledge this address.
- R9: Reading the charge MSB captures the charge LSB. A following read of 03h returns that captured byte even if the counter loaded a new value in between. A read of 03h with no MSB read before it returns the live byte.
- R10: A STOP or a START at any point ends the current transfer. The pointer keeps its value across transactions, so an address-plus-read with no command byte (or after a repeated START) continues from the pointer.
- R11: A pulse on `chg_ld_i` loads `chg_val_i` into the charge registers, and the new value shows on `charge_o`.
- R12: The slave drives SDA, or releases it, only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| alert_i | input | 1 | Device is asserting its alert |
| ara_done_o | output | 1 | Pulse: alert-response reply finished |
| status_i | input | 8 | Live status byte returned for offset 00h |
| chg_ld_i | input | 1 | Load strobe from the charge counter |
| chg_val_i | input | 16 | Charge value to load |
| wr_stb_o | output | 1 | Pulse: register written by the host |
| wr_addr_o | output | 3 | Offset of the written register |
| wr_data_o | output | 8 | Byte written |
| rd_stb_o | output | 1 | Pulse: register fetched for transmission |
| rd_addr_o | output | 3 | Offset being fetched |
| ctrl_o | output | 8 | Control register |
| charge_o | output | 16 | Accumulated charge |
| thr_hi_o | output | 16 | High charge threshold |
| thr_lo_o | output | 16 | Low charge threshold |

## Verification
The bench sweeps all 128 write addresses. A decoder that compares too few address bits would acknowledge a neighbour, and one that compares too many would miss its own address. It also reads eight bytes from every start offset and compares them with a model of the map. That catches a pointer that fails to wrap, advances on a not-acknowledge, or sends bits in the wrong order.

A burst write that passes through 00h shows whether the status slot is written or strobed by mistake. Loading a new charge between the MSB and LSB reads of one transaction shows whether the capture happens: without it, the reply would mix halves of two counter values. The alert-response address is tried with the alert low and with it high, because a design that ignores the gate would answer the shared address while idle.

// File: rtl/gauge_bus_pkg.sv
package gauge_bus_pkg;
  localparam int unsigned MAP_DEPTH = 8;
  localparam int unsigned PTR_W     = $clog2(MAP_DEPTH);
  localparam int unsigned BYTE_W    = 8;

  localparam logic [PTR_W-1:0] OFS_STATUS = 3'd0;
  localparam logic [PTR_W-1:0] OFS_CTRL   = 3'd1;
  localparam logic [PTR_W-1:0] OFS_CHG_HI = 3'd2;
  localparam logic [PTR_W-1:0] OFS_CHG_LO = 3'd3;
  localparam logic [PTR_W-1:0] OFS_THH_HI = 3'd4;
  localparam logic [PTR_W-1:0] OFS_THH_LO = 3'd5;
  localparam logic [PTR_W-1:0] OFS_THL_HI = 3'd6;
  localparam logic [PTR_W-1:0] OFS_THL_LO = 3'd7;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_RX,
    LK_RX_ACK,
    LK_TX,
    LK_TX_ACK
  } link_state_e;

  typedef enum logic [1:0] {
    BT_ADDR,
    BT_CMD,
    BT_DATA
  } byte_kind_e;
endpackage

// File: rtl/bus_line_sampler.sv
module bus_line_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sr;
  logic [STAGES-1:0] sda_sr;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= scl_raw;
          sda_sr <= sda_raw;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= {scl_sr[STAGES-2:0], scl_raw};
          sda_sr <= {sda_sr[STAGES-2:0], sda_raw};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign scl_q     = scl_sr[STAGES-1];
  assign sda_q     = sda_sr[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // data edges while the clock stays high mark frame boundaries
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/bus_link_fsm.sv
module bus_link_fsm
  import gauge_bus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h64,
  parameter logic [6:0] ARA_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              alert_i,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  output logic [PTR_W-1:0]  rd_addr,
  output logic              ara_done
);
  localparam logic [BYTE_W-1:0] ARA_REPLY = {DEV_ADDR, 1'b1};
  localparam logic [BYTE_W-1:0] ARA_MATCH = {ARA_ADDR, 1'b1};

  link_state_e       st;
  byte_kind_e        kind;
  logic [2:0]        bitcnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [PTR_W-1:0]  ptr;
  logic              byte_done;
  logic              go_tx;
  logic              ara_mode;
  logic              m_ack;
  logic              tx_load;
  logic              frame_edge;

  assign frame_edge = start_det | stop_det;
  assign tx_load = scl_fall && !frame_edge &&
                   ((st == LK_RX_ACK && go_tx) ||
                    (st == LK_TX_ACK && m_ack && !ara_mode));
  assign rd_req  = tx_load && !ara_mode;
  assign rd_addr = (st == LK_TX_ACK) ? ptr + 1'b1 : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LK_IDLE;
      kind      <= BT_ADDR;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      byte_done <= 1'b0;
      go_tx     <= 1'b0;
      ara_mode  <= 1'b0;
      m_ack     <= 1'b0;
      sda_oe    <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      ara_done  <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      ara_done <= 1'b0;
      if (start_det) begin
        st        <= LK_RX;
        kind      <= BT_ADDR;
        bitcnt    <= '0;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
        ara_mode  <= 1'b0;
      end else if (stop_det) begin
        st        <= LK_IDLE;
        sda_oe    <= 1'b0;
        ara_mode  <= 1'b0;
        byte_done <= 1'b0;
      end else begin
        unique case (st)
          LK_RX: begin
            if (scl_rise) begin
              rx_sh     <= {rx_sh[BYTE_W-2:0], sda_q};
              bitcnt    <= bitcnt + 1'b1;
              byte_done <= (bitcnt == 3'd7);
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              unique case (kind)
                BT_ADDR: begin
                  if (rx_sh[7:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1;
                    st     <= LK_RX_ACK;
                    go_tx  <= rx_sh[0];
                    kind   <= BT_CMD;
                  end else if (rx_sh == ARA_MATCH && alert_i) begin
                    sda_oe   <= 1'b1;
                    st       <= LK_RX_ACK;
                    go_tx    <= 1'b1;
                    ara_mode <= 1'b1;
                  end else begin
                    st <= LK_IDLE;
                  end
                end
                BT_CMD: begin
                  sda_oe <= 1'b1;
                  st     <= LK_RX_ACK;
                  go_tx  <= 1'b0;
                  ptr    <= rx_sh[PTR_W-1:0];
                  kind   <= BT_DATA;
                end
                default: begin
                  sda_oe  <= 1'b1;
                  st      <= LK_RX_ACK;
                  go_tx   <= 1'b0;
                  wr_stb  <= (ptr != OFS_STATUS);
                  wr_addr <= ptr;
                  wr_data <= rx_sh;
                  ptr     <= ptr + 1'b1;
                end
              endcase
            end
          end
          LK_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (go_tx) begin
                tx_sh  <= ara_mode ? ARA_REPLY : rd_data;
                sda_oe <= ara_mode ? ~ARA_REPLY[7] : ~rd_data[7];
                st     <= LK_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= LK_RX;
              end
            end
          end
          LK_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                st     <= LK_TX_ACK;
              end else begin
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[BYTE_W-2];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          LK_TX_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_q;
            end else if (scl_fall) begin
              if (ara_mode) begin
                ara_done <= 1'b1;
                ara_mode <= 1'b0;
                st       <= LK_IDLE;
              end else if (m_ack) begin
                ptr    <= ptr + 1'b1;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                bitcnt <= '0;
                st     <= LK_TX;
              end else begin
                st <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (scl_q && $past(scl_q) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe)); // R12
  AST_ARA_GATED_BY_ALERT: assert property (@(posedge clk) disable iff (!rst_n) $rose(ara_mode) |-> $past(alert_i)); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (st == LK_IDLE) |-> !sda_oe); // R7
  AST_ONE_STROBE_KIND: assert property (@(posedge clk) disable iff (!rst_n) !(wr_stb && rd_req)); // R3
endmodule

// File: rtl/gauge_reg_bank.sv
module gauge_reg_bank
  import gauge_bus_pkg::*;
#(
  parameter logic [7:0]  CTRL_RST = 8'h3C,
  parameter logic [15:0] CHG_RST  = 16'h7FFF,
  parameter logic [15:0] THH_RST  = 16'hFFFF,
  parameter logic [15:0] THL_RST  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [PTR_W-1:0]  rd_addr,
  input  logic [BYTE_W-1:0] status_i,
  input  logic              chg_ld,
  input  logic [15:0]       chg_val,
  output logic [BYTE_W-1:0] rd_data,
  output logic [7:0]        ctrl_q,
  output logic [15:0]       charge_q,
  output logic [15:0]       thr_hi_q,
  output logic [15:0]       thr_lo_q
);
  logic [BYTE_W-1:0] bank [MAP_DEPTH];
  logic [BYTE_W-1:0] lo_snap;
  logic              snap_vld;

  function automatic logic [BYTE_W-1:0] reset_byte(input int unsigned idx);
    unique case (idx)
      1:       return CTRL_RST;
      2:       return CHG_RST[15:8];
      3:       return CHG_RST[7:0];
      4:       return THH_RST[15:8];
      5:       return THH_RST[7:0];
      6:       return THL_RST[15:8];
      7:       return THL_RST[7:0];
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAP_DEPTH; i++) bank[i] <= reset_byte(i);
    end else begin
      if (chg_ld) begin
        bank[OFS_CHG_HI] <= chg_val[15:8];
        bank[OFS_CHG_LO] <= chg_val[7:0];
      end
      if (wr_stb && wr_addr != OFS_STATUS) bank[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_snap  <= '0;
      snap_vld <= 1'b0;
    end else begin
      if (rd_req && rd_addr == OFS_CHG_HI) begin
        lo_snap  <= bank[OFS_CHG_LO];
        snap_vld <= 1'b1;
      end else if ((rd_req && rd_addr == OFS_CHG_LO) ||
                   (wr_stb && (wr_addr == OFS_CHG_HI || wr_addr == OFS_CHG_LO))) begin
        snap_vld <= 1'b0;
      end
    end
  end

  always_comb begin
    if (rd_addr == OFS_STATUS)                  rd_data = status_i;
    else if (rd_addr == OFS_CHG_LO && snap_vld) rd_data = lo_snap;
    else                                        rd_data = bank[rd_addr];
  end

  assign ctrl_q   = bank[OFS_CTRL];
  assign charge_q = {bank[OFS_CHG_HI], bank[OFS_CHG_LO]};
  assign thr_hi_q = {bank[OFS_THH_HI], bank[OFS_THH_LO]};
  assign thr_lo_q = {bank[OFS_THL_HI], bank[OFS_THL_LO]};

  AST_STATUS_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> wr_addr != OFS_STATUS); // R5
  AST_WR_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R3
  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!$past(wr_stb) || $past(wr_addr) != OFS_CTRL) |-> $stable(ctrl_q)); // R5
endmodule

// File: rtl/gauge_bus_slave.sv
module gauge_bus_slave
  import gauge_bus_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h64,
  parameter logic [6:0]  ARA_ADDR    = 7'h0C,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  CTRL_RST    = 8'h3C,
  parameter logic [15:0] CHG_RST     = 16'h7FFF,
  parameter logic [15:0] THH_RST     = 16'hFFFF,
  parameter logic [15:0] THL_RST     = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic        alert_i,
  output logic        ara_done_o,
  input  logic [7:0]  status_i,
  input  logic        chg_ld_i,
  input  logic [15:0] chg_val_i,
  output logic        wr_stb_o,
  output logic [2:0]  wr_addr_o,
  output logic [7:0]  wr_data_o,
  output logic        rd_stb_o,
  output logic [2:0]  rd_addr_o,
  output logic [7:0]  ctrl_o,
  output logic [15:0] charge_o,
  output logic [15:0] thr_hi_o,
  output logic [15:0] thr_lo_o
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rd_data;

  bus_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_link_fsm #(.DEV_ADDR(DEV_ADDR), .ARA_ADDR(ARA_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .alert_i(alert_i),
    .rd_data(rd_data), .sda_oe(sda_oe_o), .wr_stb(wr_stb_o),
    .wr_addr(wr_addr_o), .wr_data(wr_data_o), .rd_req(rd_stb_o),
    .rd_addr(rd_addr_o), .ara_done(ara_done_o)
  );

  gauge_reg_bank #(
    .CTRL_RST(CTRL_RST), .CHG_RST(CHG_RST), .THH_RST(THH_RST), .THL_RST(THL_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb_o), .wr_addr(wr_addr_o),
    .wr_data(wr_data_o), .rd_req(rd_stb_o), .rd_addr(rd_addr_o),
    .status_i(status_i), .chg_ld(chg_ld_i), .chg_val(chg_val_i),
    .rd_data(rd_data), .ctrl_q(ctrl_o), .charge_q(charge_o),
    .thr_hi_q(thr_hi_o), .thr_lo_q(thr_lo_o)
  );
endmodule

// File: tb/tb_gauge_bus_slave.sv
module tb_gauge_bus_slave;
  localparam int H = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m, sda_m;
  logic        sda_oe, ara_done, alert;
  logic [7:0]  status;
  logic        chg_ld;
  logic [15:0] chg_val;
  logic        wr_stb, rd_stb;
  logic [2:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, ctrl;
  logic [15:0] charge, thr_hi, thr_lo;
  wire         sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0, wr_cnt = 0, ara_cnt = 0, sda_viol = 0;
  bit finished = 0;
  logic [7:0] mdl [8];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  gauge_bus_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .alert_i(alert), .ara_done_o(ara_done), .status_i(status), .chg_ld_i(chg_ld),
    .chg_val_i(chg_val), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_stb_o(rd_stb), .rd_addr_o(rd_addr), .ctrl_o(ctrl), .charge_o(charge),
    .thr_hi_o(thr_hi), .thr_lo_o(thr_lo)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_stb) wr_cnt++;
      if (ara_done) ara_cnt++;
      if (sda_oe != prev_oe && scl_m && prev_scl) sda_viol++;
    end
    prev_oe  <= sda_oe;
    prev_scl <= scl_m;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    tick(H/2); sda_m = 1'b0; tick(H/2); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(H/2); sda_m = b[i]; tick(H/2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    end
    tick(H/2); sda_m = 1'b1; tick(H/2); scl_m = 1'b1; tick(H/2);
    ack = !sda_line; tick(H/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    tick(H/2); sda_m = 1'b1; tick(H/2);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b1; tick(H/2); b[i] = sda_line; tick(H/2); scl_m = 1'b0; tick(H);
    end
    sda_m = !mack; tick(H/2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
  endtask

  task automatic wr_burst(input logic [7:0] p, input int n, output int acks);
    bit ak;
    acks = 0;
    bus_start();
    send_byte(8'hC8, ak); acks += int'(ak);
    send_byte(p, ak); acks += int'(ak);
    for (int k = 0; k < n; k++) begin send_byte(wbuf[k], ak); acks += int'(ak); end
    bus_stop();
  endtask

  task automatic rd_burst(input logic [7:0] p, input int n, output int acks);
    bit ak;
    acks = 0;
    bus_start();
    send_byte(8'hC8, ak); acks += int'(ak);
    send_byte(p, ak); acks += int'(ak);
    bus_start();
    send_byte(8'hC9, ak); acks += int'(ak);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    bus_stop();
  endtask

  initial begin
    tick(190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    int acks, w0;
    bit ak;
    logic [7:0] b;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0; alert = 1'b0;
    status = 8'h81; chg_ld = 1'b0; chg_val = '0;
    tick(5); rst_n = 1'b1; tick(4);

    chk("R1 ctrl reset", ctrl, 8'h3C);
    chk("R1 charge reset", charge, 16'h7FFF);
    chk("R1 thr_hi reset", thr_hi, 16'hFFFF);
    chk("R1 thr_lo reset", thr_lo, 16'h0000);
    mdl[0] = 8'h81; mdl[1] = 8'h3C; mdl[2] = 8'h7F; mdl[3] = 8'hFF;
    mdl[4] = 8'hFF; mdl[5] = 8'hFF; mdl[6] = 8'h00; mdl[7] = 8'h00;

    // R2: every 7-bit address with write direction
    for (int a = 0; a < 128; a++) begin
      bus_start(); send_byte(8'(a * 2), ak); bus_stop();
      chk("R2 address ack", int'(ak), int'(a == 'h64));
    end
    bus_start(); send_byte(8'hCA, ak); acks = int'(ak);
    send_byte(8'h01, ak); acks += int'(ak);
    send_byte(8'h77, ak); acks += int'(ak); bus_stop();
    chk("R2 foreign acks", acks, 0);
    chk("R2 foreign no change", ctrl, 8'h3C);
    chk("R2 foreign no strobe", wr_cnt, 0);

    // R3 single write
    wbuf[0] = 8'h5A;
    wr_burst(8'h01, 1, acks);
    chk("R3 write acks", acks, 3);
    chk("R3 ctrl written", ctrl, 8'h5A);
    chk("R3 strobe count", wr_cnt, 1);
    mdl[1] = 8'h5A;

    // R4 wrap, R5 status slot discarded
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h55;
    w0 = wr_cnt;
    wr_burst(8'h06, 5, acks);
    chk("R5 burst acks incl status", acks, 7);
    chk("R4 low threshold", thr_lo, 16'h1122);
    chk("R4 wrapped ctrl", ctrl, 8'h44);
    chk("R4 wrapped charge", charge, 16'h55FF);
    chk("R5 strobes skip status", wr_cnt - w0, 4);
    mdl[6] = 8'h11; mdl[7] = 8'h22; mdl[1] = 8'h44; mdl[2] = 8'h55;

    // R6/R7 read sweep from every start offset
    for (int p = 0; p < 8; p++) begin
      rd_burst(8'(p), 8, acks);
      chk("R6 read acks", acks, 3);
      for (int k = 0; k < 8; k++)
        chk("R7 read sweep data", rbuf[k], mdl[(p + k) % 8]);
    end

    // R7 NAK releases the line
    bus_start(); send_byte(8'hC8, ak); send_byte(8'h04, ak);
    bus_start(); send_byte(8'hC9, ak); recv_byte(b, 1'b0);
    tick(H); chk("R7 released after NAK", int'(sda_line), 1);
    tick(H); chk("R7 still released", int'(sda_line), 1);
    bus_stop();
    chk("R6 nak byte", b, mdl[4]);

    // R10 pointer kept across STOP; read with no command byte
    bus_start(); send_byte(8'hC8, ak); send_byte(8'h05, ak); bus_stop();
    bus_start(); send_byte(8'hC9, ak); recv_byte(b, 1'b0); bus_stop();
    chk("R10 pointer kept", b, mdl[5]);
    // R10 repeated START after a data byte
    bus_start(); send_byte(8'hC8, ak); send_byte(8'h04, ak); send_byte(8'h9A, ak);
    bus_start(); send_byte(8'hC9, ak); recv_byte(b, 1'b0); bus_stop();
    mdl[4] = 8'h9A;
    chk("R10 rstart continues", b, mdl[5]);
    chk("R10 threshold written", thr_hi, 16'h9AFF);

    // R8 alert response
    bus_start(); send_byte(8'h19, ak); bus_stop();
    chk("R8 no ack without alert", int'(ak), 0);
    alert = 1'b1;
    bus_start(); send_byte(8'h19, ak);
    if (ak) recv_byte(b, 1'b0);
    bus_stop();
    chk("R8 ack with alert", int'(ak), 1);
    chk("R8 reply byte", b, 8'hC9);
    chk("R8 done pulse", ara_cnt, 1);
    alert = 1'b0;

    // R11 load, R9 coherent pair
    chg_val = 16'h1234; chg_ld = 1'b1; tick(1); chg_ld = 1'b0; tick(2);
    chk("R11 charge loaded", charge, 16'h1234);
    bus_start(); send_byte(8'hC8, ak); send_byte(8'h02, ak);
    bus_start(); send_byte(8'hC9, ak);
    recv_byte(rbuf[0], 1'b1);
    chg_val = 16'hABCD; chg_ld = 1'b1; tick(1); chg_ld = 1'b0;
    recv_byte(rbuf[1], 1'b0); bus_stop();
    chk("R9 msb", rbuf[0], 8'h12);
    chk("R9 captured lsb", rbuf[1], 8'h34);
    chk("R11 second load", charge, 16'hABCD);
    rd_burst(8'h03, 1, acks);
    chk("R9 live lsb", rbuf[0], 8'hCD);

    chk("R12 sda moved only with scl low", sda_viol, 0);
    finish_run();
  end
endmodule